// File: doc/BRIEF.md
# Lockable Indexed Configuration Port

This block is the byte-wide configuration front end of a multi-function I/O controller. Software sees only two adjacent byte addresses: an index port at the base address and a data port one address above it. After reset the configuration space is sealed. Two consecutive writes of 0x87 to the index port open it, and a write of 0xAA to the index port seals it again. While the space is open, a write to the index port picks a register and the data port reads or writes that register.

The low part of the index space holds global registers: a logical-device selector, a fixed identity byte, a revision byte and a strap register. The strap input chooses which of two base addresses the port answers at. Indices 0x30 and above belong to the logical device that the selector names. Index 0x30 holds that device's enable bit, which this block keeps for every device. All higher indices go out on a simple register bus with the selected device number, so the logical devices can keep their own registers.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the space is sealed, the index is 0x00, the device selector is 0x00, every `dev_active` bit is 0, and `io_rdata` is 0xFF.
- R2: Two consecutive index-port writes of 0x87 open the space. Any other byte written to the index port while sealed restarts the sequence.
- R3: An index-port write of 0xAA while open seals the space. The index and all registers keep their values.
- R4: While sealed, data-port reads and index-port reads return 0xFF, and data-port writes change nothing.
- R5: With the strap at 0 during reset, the index port is at 0x2E and the data port at 0x2F. With the strap at 1, they are at 0x4E and 0x4F. Accesses to any other address read 0xFF and have no effect.
- R6: Index 0x20 reads the parameter DEV_ID and index 0x21 reads DEV_REV. Data writes to either are ignored. Unlisted global indices below 0x30 read 0x00.
- R7: Index 0x26 reads the strap sampled during reset in bit 6, with every other bit 0. It is read-only.
- R8: Index 0x07 is a read/write 8-bit device selector. It picks the bank that serves indices 0x30 and above.
- R9: Bit 0 of index 0x30 is the enable of the selected device, driven on `dev_active[n]`. Bits 7:1 read 0. If the selector is NUM_LDEV or more, the write is ignored and the read returns 0x00.
- R10: When open, a data-port access to an index of 0x31 or above drives `lbus_wr` or `lbus_rd` for that cycle, with `lbus_ldn` set to the selector and `lbus_idx` set to the index. A read returns `lbus_rdata`.
- R11: Read data appears on `io_rdata` in the cycle after `io_rd`. In every cycle that follows no read, `io_rdata` is 0xFF.
- R12: While open, an index-port read returns the current index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also samples the strap |
| strap_alt_base | input | 1 | Base-address strap: 0 selects 0x2E, 1 selects 0x4E |
| io_addr | input | ADDR_W | I/O address |
| io_wr | input | 1 | Write strobe, one cycle |
| io_rd | input | 1 | Read strobe, one cycle |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| dev_active | output | NUM_LDEV | Per-device enable bits |
| lbus_ldn | output | 8 | Selected logical device for the bank bus |
| lbus_idx | output | 8 | Register index for the bank bus |
| lbus_wr | output | 1 | Bank register write strobe |
| lbus_rd | output | 1 | Bank register read strobe |
| lbus_wdata | output | 8 | Bank write data |
| lbus_rdata | input | 8 | Bank read data, valid in the same cycle as lbus_rd |

## Verification
A write takes effect at the clock edge where it is sampled. A read strobe sampled at edge N places its byte on `io_rdata` after edge N, and the byte is then valid until edge N+1. The bank strobes are combinational and share the cycle of the port access. The bench drives every stimulus on the falling edge. On each rising edge, a behavioural model updates its state from the same inputs and predicts the next `io_rdata`. The comparison is made on the following falling edge, so each prediction is checked exactly one register stage after its stimulus. Directed reads use the same timing, with expected values taken from the requirements.

// File: rtl/sio_cfg_pkg.sv
`timescale 1ns/1ps
package sio_cfg_pkg;
  typedef enum logic [1:0] {LK_SEALED, LK_HALF, LK_OPEN} lock_e;

  localparam logic [7:0] KEY_OPEN  = 8'h87;
  localparam logic [7:0] KEY_CLOSE = 8'hAA;

  localparam logic [7:0] IDX_LDN   = 8'h07;
  localparam logic [7:0] IDX_ID    = 8'h20;
  localparam logic [7:0] IDX_REV   = 8'h21;
  localparam logic [7:0] IDX_STRAP = 8'h26;
  localparam logic [7:0] IDX_ACT   = 8'h30;

  localparam int STRAP_BIT = 6;
  localparam logic [7:0] IDLE_BYTE = 8'hFF;
endpackage

// File: rtl/sio_port_decode.sv
`timescale 1ns/1ps
module sio_port_decode #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_LO = 'h2E,
  parameter logic [ADDR_W-1:0] BASE_HI = 'h4E
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              alt_base,
  output logic              hit_idx,
  output logic              hit_dat
);
  localparam logic [ADDR_W-1:0] ONE = 1;
  logic [ADDR_W-1:0] base;

  always_comb begin
    base    = alt_base ? BASE_HI : BASE_LO;
    hit_idx = (addr == base);
    hit_dat = (addr == base + ONE);
  end
endmodule

// File: rtl/sio_index_port.sv
`timescale 1ns/1ps
module sio_index_port
  import sio_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       idx_wr,
  input  logic [7:0] wdata,
  output logic       cfg_open,
  output logic [7:0] index_q
);
  lock_e st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= LK_SEALED;
      index_q <= 8'h00;
    end else if (idx_wr) begin
      case (st)
        LK_SEALED: st <= (wdata == KEY_OPEN) ? LK_HALF : LK_SEALED;
        LK_HALF:   st <= (wdata == KEY_OPEN) ? LK_OPEN : LK_SEALED;
        default: begin
          if (wdata == KEY_CLOSE) st <= LK_SEALED;
          else index_q <= wdata;
        end
      endcase
    end
  end

  assign cfg_open = (st == LK_OPEN);

  // R2
  key_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfg_open && idx_wr && wdata != KEY_OPEN) |=> (!cfg_open && st == LK_SEALED));
  // R2
  key_second_chk: assert property (@(posedge clk) disable iff (rst)
    (st == LK_HALF && idx_wr && wdata == KEY_OPEN) |=> cfg_open);
  // R3
  close_key_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_open && idx_wr && wdata == KEY_CLOSE) |=> (!cfg_open && $stable(index_q)));
  // R12
  index_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !idx_wr |=> $stable(index_q));
endmodule

// File: rtl/sio_global_regs.sv
`timescale 1ns/1ps
module sio_global_regs
  import sio_cfg_pkg::*;
#(
  parameter int NUM_LDEV = 4,
  parameter logic [7:0] DEV_ID  = 8'hA3,
  parameter logic [7:0] DEV_REV = 8'h17
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [7:0]          index,
  input  logic [7:0]          wdata,
  input  logic                strap_q,
  output logic [7:0]          ldn_q,
  output logic [NUM_LDEV-1:0] dev_active,
  output logic [7:0]          rd_data
);
  localparam int LDN_W = (NUM_LDEV > 1) ? $clog2(NUM_LDEV) : 1;

  logic ldn_valid;
  assign ldn_valid = ({24'd0, ldn_q} < NUM_LDEV);

  always_ff @(posedge clk) begin
    if (rst) ldn_q <= 8'h00;
    else if (wr_en && index == IDX_LDN) ldn_q <= wdata;
  end

  for (genvar g = 0; g < NUM_LDEV; g++) begin : g_act
    always_ff @(posedge clk) begin
      if (rst) dev_active[g] <= 1'b0;
      else if (wr_en && index == IDX_ACT && ldn_q == 8'(g)) dev_active[g] <= wdata[0];
    end
  end

  always_comb begin
    rd_data = 8'h00;
    case (index)
      IDX_LDN:   rd_data = ldn_q;
      IDX_ID:    rd_data = DEV_ID;
      IDX_REV:   rd_data = DEV_REV;
      IDX_STRAP: rd_data[STRAP_BIT] = strap_q;
      IDX_ACT:   if (ldn_valid) rd_data[0] = dev_active[ldn_q[LDN_W-1:0]];
      default:   rd_data = 8'h00;
    endcase
  end

  // R8
  ldn_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(ldn_q));
  // R9
  act_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && index == IDX_ACT) |=> $stable(dev_active));
endmodule

// File: rtl/sio_cfg_port.sv
`timescale 1ns/1ps
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int NUM_LDEV = 4,
  parameter logic [7:0] DEV_ID  = 8'hA3,
  parameter logic [7:0] DEV_REV = 8'h17
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                strap_alt_base,
  input  logic [ADDR_W-1:0]   io_addr,
  input  logic                io_wr,
  input  logic                io_rd,
  input  logic [7:0]          io_wdata,
  output logic [7:0]          io_rdata,
  output logic [NUM_LDEV-1:0] dev_active,
  output logic [7:0]          lbus_ldn,
  output logic [7:0]          lbus_idx,
  output logic                lbus_wr,
  output logic                lbus_rd,
  output logic [7:0]          lbus_wdata,
  input  logic [7:0]          lbus_rdata
);
  logic       strap_q;
  logic       hit_idx, hit_dat;
  logic       cfg_open;
  logic [7:0] index_q, ldn_q, glb_rdata, rd_next;
  logic       remote, dat_wr, dat_rd;

  always_ff @(posedge clk) begin
    if (rst) strap_q <= strap_alt_base;
  end

  sio_port_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(io_addr), .alt_base(strap_q), .hit_idx(hit_idx), .hit_dat(hit_dat)
  );

  sio_index_port u_idx (
    .clk(clk), .rst(rst), .idx_wr(io_wr && hit_idx), .wdata(io_wdata),
    .cfg_open(cfg_open), .index_q(index_q)
  );

  assign remote = (index_q > IDX_ACT);
  assign dat_wr = io_wr && hit_dat && cfg_open;
  assign dat_rd = io_rd && hit_dat && cfg_open;

  sio_global_regs #(.NUM_LDEV(NUM_LDEV), .DEV_ID(DEV_ID), .DEV_REV(DEV_REV)) u_glb (
    .clk(clk), .rst(rst), .wr_en(dat_wr && !remote), .index(index_q),
    .wdata(io_wdata), .strap_q(strap_q), .ldn_q(ldn_q),
    .dev_active(dev_active), .rd_data(glb_rdata)
  );

  assign lbus_ldn   = ldn_q;
  assign lbus_idx   = index_q;
  assign lbus_wdata = io_wdata;
  assign lbus_wr    = dat_wr && remote;
  assign lbus_rd    = dat_rd && remote;

  always_comb begin
    rd_next = IDLE_BYTE;
    if (io_rd && hit_idx && cfg_open) rd_next = index_q;
    else if (dat_rd) rd_next = remote ? lbus_rdata : glb_rdata;
  end

  always_ff @(posedge clk) begin
    if (rst) io_rdata <= IDLE_BYTE;
    else io_rdata <= rd_next;
  end

  // R4
  sealed_read_chk: assert property (@(posedge clk) disable iff (rst)
    (io_rd && hit_dat && !cfg_open) |=> (io_rdata == 8'hFF));
  // R10
  bank_range_chk: assert property (@(posedge clk) disable iff (rst)
    (lbus_wr || lbus_rd) |-> (lbus_idx > 8'h30 && cfg_open && !(lbus_wr && lbus_rd)));
  // R11
  idle_byte_chk: assert property (@(posedge clk) disable iff (rst)
    !io_rd |=> (io_rdata == 8'hFF));
endmodule

// File: tb/test_sio_cfg_port.sv
`timescale 1ns/1ps
module test_sio_cfg_port;
  localparam logic [7:0] T_ID  = 8'h5C;
  localparam logic [7:0] T_REV = 8'h09;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic strap = 1'b0;
  logic [15:0] io_addr = 16'h0;
  logic io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0] io_wdata = 8'h0;
  logic [7:0] io_rdata;
  logic [3:0] dev_active;
  logic [7:0] lbus_ldn, lbus_idx, lbus_wdata, lbus_rdata;
  logic lbus_wr, lbus_rd;

  int checks = 0, errors = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  sio_cfg_port #(.ADDR_W(16), .NUM_LDEV(4), .DEV_ID(T_ID), .DEV_REV(T_REV)) i_sio_cfg_port (
    .clk(clk), .rst(rst), .strap_alt_base(strap), .io_addr(io_addr), .io_wr(io_wr),
    .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata), .dev_active(dev_active),
    .lbus_ldn(lbus_ldn), .lbus_idx(lbus_idx), .lbus_wr(lbus_wr), .lbus_rd(lbus_rd),
    .lbus_wdata(lbus_wdata), .lbus_rdata(lbus_rdata)
  );

  // bench-side logical device banks
  logic [7:0] bank_mem [0:1023];
  initial for (int i = 0; i < 1024; i++) bank_mem[i] = 8'h00;
  assign lbus_rdata = bank_mem[{lbus_ldn[1:0], lbus_idx}];
  always @(posedge clk) if (lbus_wr) bank_mem[{lbus_ldn[1:0], lbus_idx}] <= lbus_wdata;

  // behavioural reference model
  bit m_open, m_half, m_strap, m_run;
  int m_idx, m_ldn;
  bit [3:0] m_act;
  int m_bank [4][256];
  logic [7:0] exp_rdata = 8'hFF;

  function automatic int m_read(int idx);
    if (idx > 'h30) return m_bank[m_ldn % 4][idx];
    if (idx == 'h07) return m_ldn;
    if (idx == 'h20) return T_ID;
    if (idx == 'h21) return T_REV;
    if (idx == 'h26) return m_strap ? 'h40 : 0;
    if (idx == 'h30) return (m_ldn < 4) ? int'(m_act[m_ldn]) : 0;
    return 0;
  endfunction

  initial for (int a = 0; a < 4; a++) for (int b = 0; b < 256; b++) m_bank[a][b] = 0;

  always @(posedge clk) begin
    int base, nxt;
    if (rst) begin
      m_open = 0; m_half = 0; m_idx = 0; m_ldn = 0; m_act = '0;
      m_strap = strap; exp_rdata = 8'hFF; m_run = 1;
    end else begin
      base = m_strap ? 'h4E : 'h2E;
      nxt = 'hFF;
      if (io_rd && io_addr == base && m_open) nxt = m_idx;
      else if (io_rd && io_addr == base + 1 && m_open) nxt = m_read(m_idx);
      if (io_wr && io_addr == base) begin
        if (!m_open) begin
          if (io_wdata == 8'h87) begin
            if (m_half) begin m_open = 1; m_half = 0; end else m_half = 1;
          end else m_half = 0;
        end else if (io_wdata == 8'hAA) m_open = 0;
        else m_idx = io_wdata;
      end else if (io_wr && io_addr == base + 1 && m_open) begin
        if (m_idx > 'h30) m_bank[m_ldn % 4][m_idx] = io_wdata;
        else if (m_idx == 'h07) m_ldn = io_wdata;
        else if (m_idx == 'h30 && m_ldn < 4) m_act[m_ldn] = io_wdata[0];
      end
      exp_rdata = 8'(nxt);
    end
  end

  always @(negedge clk) begin
    if (m_run) begin
      checks++;
      if (io_rdata !== exp_rdata || dev_active !== m_act) begin
        errors++;
        $display("FAIL %s model: rdata %h act %b expected %h %b",
                 cur_req, io_rdata, dev_active, exp_rdata, m_act);
      end
    end
  end

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [15:0] a, input logic [7:0] e, input string tag);
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    checks++;
    if (io_rdata !== e) begin
      errors++;
      $display("FAIL %s addr %h: got %h expected %h", tag, a, io_rdata, e);
    end
  endtask

  task automatic act_chk(input logic [3:0] e, input string tag);
    checks++;
    if (dev_active !== e) begin
      errors++;
      $display("FAIL %s dev_active: got %b expected %b", tag, dev_active, e);
    end
  endtask

  task automatic do_reset(input logic s);
    strap = s; rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    do_reset(1'b0);
    // R1
    cur_req = "R1";
    act_chk(4'b0000, "R1");
    rd_chk(16'h2F, 8'hFF, "R1");
    rd_chk(16'h2E, 8'hFF, "R1");
    // R2: interrupted sequence keeps the space sealed
    cur_req = "R2";
    wr(16'h2E, 8'h87); wr(16'h2E, 8'h12); wr(16'h2E, 8'h87);
    rd_chk(16'h2F, 8'hFF, "R2");
    wr(16'h2E, 8'h87);
    // R12: index reads 0 after reset
    cur_req = "R12";
    rd_chk(16'h2E, 8'h00, "R12");
    // R6
    cur_req = "R6";
    wr(16'h2E, 8'h20); rd_chk(16'h2F, T_ID, "R6");
    wr(16'h2F, 8'h00); rd_chk(16'h2F, T_ID, "R6");
    wr(16'h2E, 8'h21); rd_chk(16'h2F, T_REV, "R6");
    wr(16'h2E, 8'h10); wr(16'h2F, 8'h77); rd_chk(16'h2F, 8'h00, "R6");
    // R7
    cur_req = "R7";
    wr(16'h2E, 8'h26); wr(16'h2F, 8'hFF); rd_chk(16'h2F, 8'h00, "R7");
    // R8
    cur_req = "R8";
    wr(16'h2E, 8'h07); wr(16'h2F, 8'h02); rd_chk(16'h2F, 8'h02, "R8");
    // R9
    cur_req = "R9";
    wr(16'h2E, 8'h30); wr(16'h2F, 8'hFF); rd_chk(16'h2F, 8'h01, "R9");
    act_chk(4'b0100, "R9");
    wr(16'h2E, 8'h07); wr(16'h2F, 8'h05);
    wr(16'h2E, 8'h30); wr(16'h2F, 8'h01); rd_chk(16'h2F, 8'h00, "R9");
    act_chk(4'b0100, "R9");
    // R10
    cur_req = "R10";
    wr(16'h2E, 8'h07); wr(16'h2F, 8'h01);
    wr(16'h2E, 8'h60); wr(16'h2F, 8'hA5);
    wr(16'h2E, 8'h07); wr(16'h2F, 8'h02);
    wr(16'h2E, 8'h60); wr(16'h2F, 8'h3C); rd_chk(16'h2F, 8'h3C, "R10");
    wr(16'h2E, 8'h07); wr(16'h2F, 8'h01);
    wr(16'h2E, 8'h60); rd_chk(16'h2F, 8'hA5, "R10");
    // R11: no read gives idle byte
    cur_req = "R11";
    @(negedge clk);
    checks++;
    if (io_rdata !== 8'hFF) begin
      errors++; $display("FAIL R11 idle: got %h expected ff", io_rdata);
    end
    // R5: wrong base address ignored
    cur_req = "R5";
    wr(16'h4E, 8'hAA); rd_chk(16'h4E, 8'hFF, "R5");
    rd_chk(16'h2E, 8'h60, "R5");
    // R3 and R4
    cur_req = "R3";
    wr(16'h2E, 8'h07);
    wr(16'h2E, 8'hAA); rd_chk(16'h2F, 8'hFF, "R3");
    cur_req = "R4";
    rd_chk(16'h2E, 8'hFF, "R4");
    wr(16'h2F, 8'h03);
    wr(16'h2E, 8'h87); wr(16'h2E, 8'h87);
    rd_chk(16'h2E, 8'h07, "R3");
    rd_chk(16'h2F, 8'h01, "R4");
    // R5 and R7 with the alternate strap
    cur_req = "R5";
    do_reset(1'b1);
    act_chk(4'b0000, "R1");
    wr(16'h2E, 8'h87); wr(16'h2E, 8'h87);
    rd_chk(16'h2F, 8'hFF, "R5");
    wr(16'h4E, 8'h87); wr(16'h4E, 8'h87);
    cur_req = "R7";
    wr(16'h4E, 8'h26); rd_chk(16'h4F, 8'h40, "R7");
    rd_chk(16'h4E, 8'h26, "R12");
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule